// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block sits inside an I/O interrupt controller, between the redirection table and the message transport. When an input line fires, the controller presents that line's entry fields together with a one-cycle `fire_i` strobe. The block works out which processors must receive the interrupt and returns the result one clock later. The result is a per-processor target mask with a valid pulse, and it carries the entry's vector, delivery mode, addressing mode, polarity and trigger along with it.

Two addressing modes are supported. In physical mode the destination is a processor ID, and the ID 0xFF addresses all processors. In logical mode the destination is an 8-bit pattern. Each processor's local controller supplies a 32-bit logical destination register on a parallel bus, and a processor is selected when its logical ID (the register's top byte) shares at least one set bit with the pattern.

Lowest-priority arbitration is not provided. An entry that requests it is rejected with an error pulse in place of a result.

Top module: `irq_dest_match`

## Requirements
- R1: With `dest_mode_i`=0 and `dest_i`=0xFF, the result mask has every one of the NUM_CPU bits set.
- R2: With `dest_mode_i`=0 and `dest_i` below NUM_CPU, the mask has exactly bit `dest_i` set.
- R3: With `dest_mode_i`=0, `dest_i` not 0xFF and `dest_i` >= NUM_CPU, the mask is zero, `valid_o` still pulses, and `no_target_o` pulses with it.
- R4: With `dest_mode_i`=1, mask bit i is set exactly when bits 31:24 of `ldr_i[i*32 +: 32]` ANDed with `dest_i` is non-zero. Bits 23:0 have no effect. An all-zero result pulses `no_target_o`.
- R5: Delivery mode 3'b001 (lowest priority) in either addressing mode pulses `err_o` and clears the mask. `valid_o` and `no_target_o` stay low for that request.
- R6: `vector_o`, `dmode_o`, `dest_mode_o`, `polarity_o` and `trigger_o` are updated with the same edge as the mask and equal the inputs sampled with `fire_i`.
- R7: Every `fire_i` cycle gives exactly one result one clock later, including back-to-back fires. In a cycle without `fire_i`, `valid_o`, `err_o` and `no_target_o` fall low, and the mask and fields hold their values.
- R8: While `rst_ni` is low, `valid_o`, `err_o`, `no_target_o` and `mask_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fire_i | input | 1 | Line-fire strobe, one resolution per high cycle |
| vector_i | input | 8 | Entry vector |
| dmode_i | input | 3 | Entry delivery mode, 3'b001 = lowest priority |
| dest_mode_i | input | 1 | 0 = physical, 1 = logical |
| polarity_i | input | 1 | Entry polarity |
| trigger_i | input | 1 | Entry trigger mode |
| dest_i | input | 8 | Entry destination field |
| ldr_i | input | NUM_CPU*32 | Logical destination registers, processor i at bits i*32 +: 32 |
| valid_o | output | 1 | Result pulse |
| err_o | output | 1 | Unsupported-mode pulse |
| no_target_o | output | 1 | Valid result with an empty mask |
| mask_o | output | NUM_CPU | Target processor mask |
| vector_o | output | 8 | Vector carried with the result |
| dmode_o | output | 3 | Delivery mode carried with the result |
| dest_mode_o | output | 1 | Addressing mode carried with the result |
| polarity_o | output | 1 | Polarity carried with the result |
| trigger_o | output | 1 | Trigger carried with the result |

## Verification
The logical comparators and the lowest-priority rejection both act on the same request when a logical entry asks for lowest priority. The bench provokes this by firing such an entry while several logical IDs overlap the pattern, so the comparators on their own would produce a non-empty mask. The expected result is an error pulse with a zero mask and no valid or no-target pulse. The same overlap is then fired in fixed mode, and that request must return the full mask, which shows that the rejection, not an empty match, cleared the first result.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;
  localparam int unsigned VEC_W  = 8;
  localparam int unsigned DEST_W = 8;
  localparam int unsigned LDR_W  = 32;
  localparam logic [2:0]        DM_LOWEST  = 3'b001;
  localparam logic [DEST_W-1:0] DEST_BCAST = '1;

  typedef struct packed {
    logic [VEC_W-1:0] vector;
    logic [2:0]       dmode;
    logic             dest_mode;
    logic             polarity;
    logic             trigger;
  } redir_fields_t;
endpackage

// File: rtl/irq_phys_decode.sv
module irq_phys_decode
  import irq_dest_pkg::*;
#(
  parameter int unsigned NUM_CPU = 8
) (
  input  logic [DEST_W-1:0]  dest_i,
  output logic [NUM_CPU-1:0] mask_o
);
  logic bcast;
  assign bcast = (dest_i == DEST_BCAST);

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
    assign mask_o[i] = bcast | (32'(dest_i) == 32'(i));
  end
endmodule

// File: rtl/irq_logic_match.sv
module irq_logic_match
  import irq_dest_pkg::*;
#(
  parameter int unsigned NUM_CPU = 8
) (
  input  logic [DEST_W-1:0]        dest_i,
  input  logic [NUM_CPU*LDR_W-1:0] ldr_i,
  output logic [NUM_CPU-1:0]       mask_o
);
  localparam int unsigned ID_LSB = LDR_W - DEST_W;

  logic [NUM_CPU-1:0] unused_low;

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
    logic [DEST_W-1:0] log_id;
    assign log_id        = ldr_i[i*LDR_W + ID_LSB +: DEST_W];
    assign mask_o[i]     = |(log_id & dest_i);
    assign unused_low[i] = ^ldr_i[i*LDR_W +: ID_LSB];
  end
endmodule

// File: rtl/irq_dest_match.sv
module irq_dest_match
  import irq_dest_pkg::*;
#(
  parameter int unsigned NUM_CPU = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     fire_i,
  input  logic [VEC_W-1:0]         vector_i,
  input  logic [2:0]               dmode_i,
  input  logic                     dest_mode_i,
  input  logic                     polarity_i,
  input  logic                     trigger_i,
  input  logic [DEST_W-1:0]        dest_i,
  input  logic [NUM_CPU*LDR_W-1:0] ldr_i,
  output logic                     valid_o,
  output logic                     err_o,
  output logic                     no_target_o,
  output logic [NUM_CPU-1:0]       mask_o,
  output logic [VEC_W-1:0]         vector_o,
  output logic [2:0]               dmode_o,
  output logic                     dest_mode_o,
  output logic                     polarity_o,
  output logic                     trigger_o
);
  logic [NUM_CPU-1:0] phys_mask, log_mask, sel_mask;
  logic               lowest;
  redir_fields_t      fields_d, fields_q;

  irq_phys_decode #(.NUM_CPU(NUM_CPU)) i_phys (
    .dest_i (dest_i),
    .mask_o (phys_mask)
  );

  irq_logic_match #(.NUM_CPU(NUM_CPU)) i_logic (
    .dest_i (dest_i),
    .ldr_i  (ldr_i),
    .mask_o (log_mask)
  );

  always_comb begin
    sel_mask = dest_mode_i ? log_mask : phys_mask;
    lowest   = (dmode_i == DM_LOWEST);
    fields_d = '{vector: vector_i, dmode: dmode_i, dest_mode: dest_mode_i,
                 polarity: polarity_i, trigger: trigger_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      err_o       <= 1'b0;
      no_target_o <= 1'b0;
      mask_o      <= '0;
      fields_q    <= '0;
    end else if (fire_i) begin
      valid_o     <= !lowest;
      err_o       <= lowest;
      no_target_o <= !lowest && (sel_mask == '0);
      mask_o      <= lowest ? '0 : sel_mask;
      fields_q    <= fields_d;
    end else begin
      valid_o     <= 1'b0;
      err_o       <= 1'b0;
      no_target_o <= 1'b0;
    end
  end

  assign vector_o    = fields_q.vector;
  assign dmode_o     = fields_q.dmode;
  assign dest_mode_o = fields_q.dest_mode;
  assign polarity_o  = fields_q.polarity;
  assign trigger_o   = fields_q.trigger;
endmodule

// File: rtl/irq_dest_chk.sv
module irq_dest_chk
  import irq_dest_pkg::*;
#(
  parameter int unsigned NUM_CPU = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                fire_i,
  input logic [VEC_W-1:0]    vector_i,
  input logic [2:0]          dmode_i,
  input logic                dest_mode_i,
  input logic [DEST_W-1:0]   dest_i,
  input logic                valid_o,
  input logic                err_o,
  input logic                no_target_o,
  input logic [NUM_CPU-1:0]  mask_o,
  input logic [VEC_W-1:0]    vector_o
);
  p_bcast_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && !dest_mode_i && dest_i == DEST_BCAST && dmode_i != DM_LOWEST
    |=> mask_o == '1);

  p_phys_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && !dest_mode_i && dest_i != DEST_BCAST
    |=> $onehot0(mask_o));

  p_empty_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (no_target_o == (mask_o == '0)));

  p_lowest_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && dmode_i == DM_LOWEST |=> err_o && !valid_o && mask_o == '0);

  p_err_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_o && (valid_o || no_target_o)));

  p_vector_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> vector_o == $past(vector_i));

  p_result_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && dmode_i != DM_LOWEST |=> valid_o);

  p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> !valid_o && !err_o && $stable(mask_o));
endmodule

bind irq_dest_match irq_dest_chk #(.NUM_CPU(NUM_CPU)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fire_i      (fire_i),
  .vector_i    (vector_i),
  .dmode_i     (dmode_i),
  .dest_mode_i (dest_mode_i),
  .dest_i      (dest_i),
  .valid_o     (valid_o),
  .err_o       (err_o),
  .no_target_o (no_target_o),
  .mask_o      (mask_o),
  .vector_o    (vector_o)
);

// File: tb/test_irq_dest_match.sv
module test_irq_dest_match;
  localparam int unsigned NUM_CPU = 8;

  logic                  clk = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  fire_i = 1'b0;
  logic [7:0]            vector_i = '0;
  logic [2:0]            dmode_i = '0;
  logic                  dest_mode_i = 1'b0;
  logic                  polarity_i = 1'b0;
  logic                  trigger_i = 1'b0;
  logic [7:0]            dest_i = '0;
  logic [NUM_CPU*32-1:0] ldr_i = '0;
  logic                  valid_o, err_o, no_target_o;
  logic [NUM_CPU-1:0]    mask_o;
  logic [7:0]            vector_o;
  logic [2:0]            dmode_o;
  logic                  dest_mode_o, polarity_o, trigger_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  irq_dest_match #(.NUM_CPU(NUM_CPU)) i_irq_dest_match (
    .clk_i(clk), .rst_ni(rst_ni), .fire_i(fire_i), .vector_i(vector_i),
    .dmode_i(dmode_i), .dest_mode_i(dest_mode_i), .polarity_i(polarity_i),
    .trigger_i(trigger_i), .dest_i(dest_i), .ldr_i(ldr_i),
    .valid_o(valid_o), .err_o(err_o), .no_target_o(no_target_o),
    .mask_o(mask_o), .vector_o(vector_o), .dmode_o(dmode_o),
    .dest_mode_o(dest_mode_o), .polarity_o(polarity_o), .trigger_o(trigger_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic logic [NUM_CPU-1:0] exp_logical(input logic [7:0] d);
    logic [NUM_CPU-1:0] m = '0;
    for (int i = 0; i < NUM_CPU; i++) m[i] = |(ldr_i[i*32+24 +: 8] & d);
    return m;
  endfunction

  // drive one request; returns at the negedge after the capturing edge
  task automatic fire(input logic [7:0] vec, input logic [2:0] dm, input logic md,
                      input logic pol, input logic trg, input logic [7:0] dst);
    @(negedge clk);
    vector_i = vec; dmode_i = dm; dest_mode_i = md;
    polarity_i = pol; trigger_i = trg; dest_i = dst; fire_i = 1'b1;
    @(negedge clk);
    fire_i = 1'b0;
  endtask

  task automatic chk_result(input string tag, input logic v, input logic e,
                            input logic nt, input logic [NUM_CPU-1:0] m);
    chk({tag, " valid"}, 32'(valid_o), 32'(v));
    chk({tag, " err"}, 32'(err_o), 32'(e));
    chk({tag, " no_target"}, 32'(no_target_o), 32'(nt));
    chk({tag, " mask"}, 32'(mask_o), 32'(m));
  endtask

  task automatic t_reset();
    chk_result("R8 reset", 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_bcast();
    fire(8'h31, 3'd0, 1'b0, 1'b1, 1'b0, 8'hFF);
    chk_result("R1 broadcast", 1'b1, 1'b0, 1'b0, '1);
    chk("R6 vector", 32'(vector_o), 32'h31);
    chk("R6 fields", {27'd0, dmode_o, dest_mode_o, polarity_o, trigger_o}, 32'b000_0_1_0);
  endtask

  task automatic t_phys();
    for (int d = 0; d < NUM_CPU; d += 3) begin
      fire(8'h40, 3'd4, 1'b0, 1'b0, 1'b1, 8'(d));
      chk_result("R2 physical id", 1'b1, 1'b0, 1'b0, NUM_CPU'(1) << d);
    end
    fire(8'h41, 3'd0, 1'b0, 1'b0, 1'b1, 8'(NUM_CPU - 1));
    chk_result("R2 top id", 1'b1, 1'b0, 1'b0, NUM_CPU'(1) << (NUM_CPU - 1));
    chk("R6 fields", {27'd0, dmode_o, dest_mode_o, polarity_o, trigger_o}, 32'b000_0_0_1);
  endtask

  task automatic t_phys_miss();
    fire(8'h50, 3'd0, 1'b0, 1'b0, 1'b0, 8'(NUM_CPU));
    chk_result("R3 just past range", 1'b1, 1'b0, 1'b1, '0);
    fire(8'h51, 3'd0, 1'b0, 1'b0, 1'b0, 8'hFE);
    chk_result("R3 id FE", 1'b1, 1'b0, 1'b1, '0);
  endtask

  task automatic t_logical();
    for (int i = 0; i < NUM_CPU; i++)
      ldr_i[i*32 +: 32] = {(i == NUM_CPU - 1) ? 8'h81 : 8'(1 << i), 24'hFFFFFF};
    fire(8'h60, 3'd0, 1'b1, 1'b0, 1'b0, 8'h01);
    chk_result("R4 shared bit", 1'b1, 1'b0, 1'b0, exp_logical(8'h01));
    chk("R4 shared bit value", 32'(mask_o), 32'h81);
    fire(8'h61, 3'd0, 1'b1, 1'b0, 1'b0, 8'h06);
    chk_result("R4 two ids", 1'b1, 1'b0, 1'b0, 8'h06);
    chk("R6 logical mode out", 32'(dest_mode_o), 32'd1);
    fire(8'h62, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00);
    chk_result("R4 empty pattern", 1'b1, 1'b0, 1'b1, '0);
  endtask

  task automatic t_lowest();
    fire(8'h70, 3'b001, 1'b0, 1'b0, 1'b0, 8'h02);
    chk_result("R5 lowest physical", 1'b0, 1'b1, 1'b0, '0);
    chk("R6 dmode out", 32'(dmode_o), 32'd1);
    // comparators would match several ids; rejection must win
    fire(8'h71, 3'b001, 1'b1, 1'b0, 1'b0, 8'hFF);
    chk_result("R5 lowest logical", 1'b0, 1'b1, 1'b0, '0);
    fire(8'h72, 3'd0, 1'b1, 1'b0, 1'b0, 8'hFF);
    chk_result("R5 same pattern fixed", 1'b1, 1'b0, 1'b0, '1);
  endtask

  task automatic t_idle_hold();
    fire(8'h80, 3'd0, 1'b0, 1'b0, 1'b0, 8'd3);
    @(negedge clk);
    @(negedge clk);
    chk_result("R7 idle hold", 1'b0, 1'b0, 1'b0, 8'h08);
    chk("R7 vector hold", 32'(vector_o), 32'h80);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    vector_i = 8'h90; dmode_i = 3'd0; dest_mode_i = 1'b0; dest_i = 8'd1; fire_i = 1'b1;
    @(negedge clk);
    chk_result("R7 first of pair", 1'b1, 1'b0, 1'b0, 8'h02);
    vector_i = 8'h91; dmode_i = 3'b001; dest_i = 8'd2;
    @(negedge clk);
    chk_result("R7 second of pair", 1'b0, 1'b1, 1'b0, '0);
    chk("R7 second vector", 32'(vector_o), 32'h91);
    vector_i = 8'h92; dmode_i = 3'd0; dest_i = 8'd6;
    @(negedge clk);
    fire_i = 1'b0;
    chk_result("R7 third of run", 1'b1, 1'b0, 1'b0, 8'h40);
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_bcast();
    t_phys();
    t_phys_miss();
    t_logical();
    t_lowest();
    t_idle_hold();
    t_back_to_back();
    finish_run();
  end
endmodule